// File: doc/BRIEF.md
# Multi-Queue Write Port Switcher

This block is the write side of a multi-queue buffer. One shared storage array is split into a fixed number of equal regions, one region per logical queue. A producer writes 36-bit words on the write clock while the write enable is high. Each accepted word goes to the region of the queue that is currently active, at that queue's own write pointer.

To move to another queue, the producer presents the queue number together with an address-enable pulse. The change is pipelined over four write clocks. During those four clocks, writes keep landing in the old queue, so no bus slot is lost. After the fourth clock the new queue takes over. A busy output covers the switch window, and a select pulse that arrives inside the window is dropped.

A queue whose region is full rejects further writes and raises its full flag. A combinational peek port reads any stored word back by its {queue, slot} address.

Top module: `mq_write_switch`

## Requirements
- R1: After reset the present queue is 0, busy_o is low, every full flag is low, every write pointer is zero, and no switch is pending.
- R2: A rising edge with qsel_en_i high and busy_o low starts a switch to qsel_i. The level of wr_en_i on that edge makes no difference. busy_o is high from that edge on.
- R3: The sampling edge and the three edges after it are switch cycles 0 to 3. Writes accepted on any of those four edges go to the old present queue. present_q_o changes only on the cycle-3 edge, and busy_o falls on that same edge.
- R4: Writes accepted from the edge after switch cycle 3 go to the selected queue, and present_q_o shows that queue.
- R5: A qsel_en_i pulse on an edge where busy_o is high is ignored: neither the pending target nor the switch timing changes.
- R6: Any queue may be selected in any order, including the queue that is already present. Selecting the present queue still runs the full four-cycle sequence.
- R7: An accepted word is stored at slot wptr of its queue, and that queue's wptr then advances by one. The word can be read back on peek_data_o with peek_addr_i = {queue, slot}, where the queue number occupies the upper 3 bits and the slot the lower 4 bits.
- R8: A queue holds 16 words. Once a queue has 16 words, full_o[queue] is high, and writes to it are dropped: no ack, no storage change, no pointer change.
- R9: wr_ack_o is high, in the same cycle, exactly when wr_en_i is high and the present queue is not full. ack_q_o then gives the queue that receives the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write enable |
| data_i | input | 36 | Write data word |
| qsel_i | input | 3 | Queue number to switch to |
| qsel_en_i | input | 1 | Queue select enable |
| peek_addr_i | input | 7 | Storage read address {queue, slot} |
| present_q_o | output | 3 | Queue currently receiving writes |
| busy_o | output | 1 | Switch in progress |
| full_o | output | 8 | Per-queue full flags |
| wr_ack_o | output | 1 | Write accepted this cycle |
| ack_q_o | output | 3 | Queue receiving the accepted write |
| peek_data_o | output | 36 | Stored word at peek_addr_i |

## Verification
The hardest case to reach is a select pulse inside the switch window that happens together with writes and a queue that fills up on one of the switch edges. In that case the old queue must take the word, or reject it, while the new target waits. The directed part of the stimulus builds this case on purpose: it switches with the write enable low, pulses the select again during busy, and fills a queue to overflow. A long random phase then drives frequent select pulses with writes on most cycles, so many switch windows collide with full queues and with repeated selections of the same queue.

// File: rtl/mq_pkg.sv
package mq_pkg;
  localparam int unsigned NUM_Q     = 8;
  localparam int unsigned DATA_W    = 36;
  localparam int unsigned Q_DEPTH   = 16;
  localparam int unsigned SW_CYCLES = 4;
  localparam int unsigned QW        = $clog2(NUM_Q);
  localparam int unsigned SW        = $clog2(Q_DEPTH);
  typedef logic [QW-1:0] qid_t;
endpackage

// File: rtl/mq_switch_ctrl.sv
module mq_switch_ctrl
  import mq_pkg::*;
#(
  parameter int unsigned N_CYC = SW_CYCLES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_en_i,
  input  qid_t sel_q_i,
  output qid_t pq_o,
  output logic busy_o
);
  localparam int unsigned CW = (N_CYC > 1) ? $clog2(N_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(N_CYC - 1);

  logic [CW-1:0] cnt_q;
  qid_t          pq_q, nq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pq_q  <= '0;
      nq_q  <= '0;
    end else if (cnt_q == '0) begin
      if (sel_en_i) begin
        nq_q  <= sel_q_i;
        cnt_q <= CW'(1);
      end
    end else if (cnt_q == LAST) begin
      pq_q  <= nq_q;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign pq_o   = pq_q;
  assign busy_o = (cnt_q != '0);

  // R2
  sel_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_en_i && !busy_o) |=> busy_o);
  // R5
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(nq_q));
  // R3
  pq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != LAST) |=> $stable(pq_o));
  // R4
  pq_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST) |=> (pq_o == $past(nq_q) && !busy_o));
endmodule

// File: rtl/mq_wptr_bank.sv
module mq_wptr_bank
  import mq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  qid_t             wq_i,
  output logic [SW-1:0]    slot_o,
  output logic [NUM_Q-1:0] full_o
);
  logic [SW:0]      ptr_q [NUM_Q];
  logic [NUM_Q-1:0] inc;

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    assign full_o[g] = (ptr_q[g] == (SW+1)'(Q_DEPTH));
    assign inc[g]    = we_i && (wq_i == qid_t'(g)) && !full_o[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ptr_q[g] <= '0;
      else if (inc[g]) ptr_q[g] <= ptr_q[g] + (SW+1)'(1);
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      full_o[g] |=> (full_o[g] && $stable(ptr_q[g])));
  end

  assign slot_o = ptr_q[wq_i][SW-1:0];

  // R7
  one_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(inc));
endmodule

// File: rtl/mq_store.sv
module mq_store
  import mq_pkg::*;
(
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [QW+SW-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [QW+SW-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned WORDS = NUM_Q * Q_DEPTH;
  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mq_write_switch.sv
module mq_write_switch
  import mq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [QW-1:0]     qsel_i,
  input  logic              qsel_en_i,
  input  logic [QW+SW-1:0]  peek_addr_i,
  output logic [QW-1:0]     present_q_o,
  output logic              busy_o,
  output logic [NUM_Q-1:0]  full_o,
  output logic              wr_ack_o,
  output logic [QW-1:0]     ack_q_o,
  output logic [DATA_W-1:0] peek_data_o
);
  qid_t          pq;
  logic [SW-1:0] slot;

  mq_switch_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_en_i(qsel_en_i),
    .sel_q_i (qsel_i),
    .pq_o    (pq),
    .busy_o  (busy_o)
  );

  mq_wptr_bank u_wptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (wr_en_i),
    .wq_i  (pq),
    .slot_o(slot),
    .full_o(full_o)
  );

  assign wr_ack_o    = wr_en_i && !full_o[pq];
  assign ack_q_o     = pq;
  assign present_q_o = pq;

  mq_store u_store (
    .clk_i  (clk_i),
    .we_i   (wr_ack_o),
    .waddr_i({pq, slot}),
    .wdata_i(data_i),
    .raddr_i(peek_addr_i),
    .rdata_o(peek_data_o)
  );

  // R9
  ack_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ack_o |-> (wr_en_i && !full_o[ack_q_o]));
endmodule

// File: tb/mq_write_switch_bench.sv
module mq_write_switch_bench;
  import mq_pkg::*;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [DATA_W-1:0] data_i = '0;
  logic [QW-1:0]     qsel_i = '0;
  logic              qsel_en_i = 1'b0;
  logic [QW+SW-1:0]  peek_addr_i = '0;
  logic [QW-1:0]     present_q_o;
  logic              busy_o;
  logic [NUM_Q-1:0]  full_o;
  logic              wr_ack_o;
  logic [QW-1:0]     ack_q_o;
  logic [DATA_W-1:0] peek_data_o;

  always #2.5 clk_i = ~clk_i;

  mq_write_switch u_mq_write_switch (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int                m_pq, m_nq, m_cnt;
  int                m_ptr [NUM_Q];
  logic [DATA_W-1:0] m_mem [NUM_Q][Q_DEPTH];

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NUM_Q-1:0] exp_full();
    logic [NUM_Q-1:0] f;
    for (int i = 0; i < NUM_Q; i++) f[i] = (m_ptr[i] == Q_DEPTH);
    return f;
  endfunction

  function automatic bit exp_ack(bit we);
    return we && (m_ptr[m_pq] != Q_DEPTH);
  endfunction

  task automatic step(bit we, logic [DATA_W-1:0] d, bit ae, int a);
    bit ack;
    @(negedge clk_i);
    chk(present_q_o == QW'(m_pq), "R3/R4 present_q", present_q_o, m_pq);
    chk(busy_o == (m_cnt != 0), "R2/R3 busy", busy_o, m_cnt != 0);
    chk(full_o == exp_full(), "R8 full", full_o, exp_full());
    wr_en_i = we; data_i = d; qsel_en_i = ae; qsel_i = QW'(a);
    #1;
    ack = exp_ack(we);
    chk(wr_ack_o == ack, "R9 wr_ack", wr_ack_o, ack);
    if (ack) chk(ack_q_o == QW'(m_pq), "R9 ack_q", ack_q_o, m_pq);
    if (ack) begin
      m_mem[m_pq][m_ptr[m_pq]] = d;
      m_ptr[m_pq]++;
    end
    if (m_cnt == 0) begin
      if (ae) begin m_nq = a; m_cnt = 1; end
    end else if (m_cnt == SW_CYCLES - 1) begin
      m_pq = m_nq; m_cnt = 0;
    end else m_cnt++;
  endtask

  function automatic logic [DATA_W-1:0] rnd_word();
    return {$urandom, $urandom};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=1 exp=0");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7741));
    m_pq = 0; m_nq = 0; m_cnt = 0;
    for (int i = 0; i < NUM_Q; i++) m_ptr[i] = 0;
    #12 rst_ni = 1'b1;
    // R1 reset state
    @(negedge clk_i);
    chk(present_q_o == 0, "R1 present_q", present_q_o, 0);
    chk(!busy_o, "R1 busy", busy_o, 0);
    chk(full_o == '0, "R1 full", full_o, 0);
    // R7 plain writes to queue 0
    for (int i = 0; i < 3; i++) step(1, rnd_word(), 0, 0);
    // R2 switch with write enable low, R3 writes during window, R5 pulse in window
    step(0, '0, 1, 5);
    step(1, rnd_word(), 1, 2);
    step(1, rnd_word(), 1, 3);
    step(1, rnd_word(), 0, 0);
    step(1, rnd_word(), 0, 0);   // R4 lands in queue 5
    step(1, rnd_word(), 0, 0);
    // R6 reselect same queue
    step(1, rnd_word(), 1, 5);
    for (int i = 0; i < 4; i++) step(1, rnd_word(), 0, 0);
    // R8 overflow queue 5
    for (int i = 0; i < 20; i++) step(1, rnd_word(), 0, 0);
    // random phase
    for (int i = 0; i < 4000; i++)
      step(($urandom % 4) != 0, rnd_word(), ($urandom % 5) == 0, int'($urandom % NUM_Q));
    step(0, '0, 0, 0);
    // R7 storage contents
    for (int q = 0; q < NUM_Q; q++)
      for (int s = 0; s < m_ptr[q]; s++) begin
        @(negedge clk_i);
        peek_addr_i = {QW'(q), SW'(s)};
        #1;
        chk(peek_data_o == m_mem[q][s], "R7 stored word", peek_data_o, m_mem[q][s]);
      end
    finish_run();
  end
endmodule